// File: doc/BRIEF.md
# NAND Array Sector Engine

This block holds a behavioural flash array made of a main region and a separate spare region, together with a small page buffer. An engine moves data between the two one byte per clock. The caller presents a block address, a page address, an optional destination block and page, a buffer-control word and an opcode, then pulses `start`. The engine derives the physical sector from the addresses. It then loads sectors from the array into the buffer, programs sectors from the buffer into the array, copies a sector range from one place to another, or erases a whole block. When the operation finishes it raises `done` for one cycle together with the error flags.

Programming follows flash rules: the stored byte becomes the AND of its old value and the buffer byte, so bits can only fall from one to zero. Erase is the only way to bring bits back to one. The array size is set by parameters: block count, main bytes per sector, spare bytes per sector, and the density mask that the top bit of the block address selects. The buffer is open to the host through a simple byte port.

Top module: `nand_array_engine`

## Requirements
- R1: After reset `busy`, `done` and all four error flags are 0, and every array byte, main and spare, reads back as 8'hFF through a load.
- R2: The sector number is pageAddr[1:0] + ((pageAddr[7:2] + (block << 6)) << 2), giving 4 sectors per page and 256 sectors per block. Main sector s occupies array bytes s*SEC_BYTES upward.
- R3: The block index is blockAddr[11:0], ORed with DENSITY_MASK when blockAddr[15] is 1.
- R4: bufCtrl[1:0] is the sector count, where 0 means 4. bufCtrl[9:8] is the first buffer slot. Slot numbers advance modulo 4, so the buffer wraps around.
- R5: Main program (opcode 8'h80) stores old AND buffer into each byte. Main load (opcode 8'h00) copies array bytes into the buffer.
- R6: Spare load (8'h13) and spare program (8'h1A) use SPARE_BYTES per sector in a region separate from the main data, with the same count and slot rules. Neither touches main data.
- R7: Erase (8'h94 or 8'h95) sets every main and spare byte of the addressed block to 8'hFF and leaves other blocks unchanged.
- R8: Copy-back (8'h1B) loads the source sectors into the buffer, then programs them at the destination block and page using the AND rule.
- R9: An access whose first sector plus count passes the last sector, or an erase of a block that does not exist, sets errCmd together with errLoad, errProg or errErase as the opcode implies. The array is left unchanged and `done` comes one cycle after the start edge.
- R10: Any other opcode sets errCmd alone and completes one cycle after the start edge.
- R11: An operation moving N bytes keeps `busy` high for N cycles after the start edge, then pulses `done` for exactly one cycle. Copy-back moves 2*count*SEC_BYTES bytes and erase moves 256*(SEC_BYTES+SPARE_BYTES) bytes. The error flags are cleared at each accepted start and hold until the next one.
- R12: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| opcode | input | 8 | Operation code |
| blockAddr | input | 16 | Source or erase block address |
| pageAddr | input | 16 | Source page and sector address |
| destBlockAddr | input | 16 | Copy-back destination block |
| destPageAddr | input | 16 | Copy-back destination page |
| bufCtrl | input | 16 | First buffer slot [9:8], sector count [1:0] |
| bufWe | input | 1 | Host write strobe for the buffer |
| bufSpare | input | 1 | Host port selects the spare buffer |
| bufAddr | input | 4 | Host buffer byte address |
| bufWdata | input | 8 | Host buffer write data |
| bufRdata | output | 8 | Host buffer read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| errCmd | output | 1 | Command failed |
| errLoad | output | 1 | Load failed |
| errProg | output | 1 | Program failed |
| errErase | output | 1 | Erase failed |

## Verification
Some rules are checked by assertions on every cycle. A programmed byte must equal its old value ANDed with the buffer byte, and an erased byte must read all ones. At most one of load, program or erase may be strobed. The byte counter must stay inside the run length, a run must end in a single-cycle `done`, and any specific error must come with errCmd. Other behaviour only shows up through the bench's scenarios. Address arithmetic, the density fold and buffer slot wrap-around are seen by programming one place and reading back another. The same goes for spare and main isolation, copy-back contents, the fact that failed operations leave the array unchanged, and exact latencies.

// File: rtl/nand_eng_pkg.sv
package nand_eng_pkg;
  localparam logic [7:0] OP_LOAD_MAIN   = 8'h00;
  localparam logic [7:0] OP_LOAD_SPARE  = 8'h13;
  localparam logic [7:0] OP_PROG_MAIN   = 8'h80;
  localparam logic [7:0] OP_PROG_SPARE  = 8'h1A;
  localparam logic [7:0] OP_COPY_BACK   = 8'h1B;
  localparam logic [7:0] OP_ERASE_ONE   = 8'h94;
  localparam logic [7:0] OP_ERASE_MULTI = 8'h95;

  localparam int SECS_PER_BLOCK = 256;
  localparam int BUF_SLOTS      = 4;

  typedef struct packed {
    logic load;
    logic prog;
    logic erase;
    logic spare;
  } strobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_t;
  typedef enum logic [1:0] {PH_LOAD, PH_PROG, PH_ERASE_MAIN, PH_ERASE_SPARE} phase_t;
endpackage

// File: rtl/nand_eng_ctrl.sv
module nand_eng_ctrl
  import nand_eng_pkg::*;
#(
  parameter int NUM_BLOCKS   = 2,
  parameter int SEC_BYTES    = 4,
  parameter int SPARE_BYTES  = 1,
  parameter int DENSITY_MASK = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [15:0] blockAddr,
  input  logic [15:0] pageAddr,
  input  logic [15:0] destBlockAddr,
  input  logic [15:0] destPageAddr,
  input  logic [15:0] bufCtrl,
  output strobe_t     strobe,
  output logic [$clog2(NUM_BLOCKS*SECS_PER_BLOCK*SEC_BYTES)-1:0] arrIdx,
  output logic [$clog2(BUF_SLOTS*SEC_BYTES)-1:0] bufIdx,
  output logic        busy,
  output logic        done,
  output logic        errCmd,
  output logic        errLoad,
  output logic        errProg,
  output logic        errErase
);
  localparam int TOTAL_SECS = NUM_BLOCKS * SECS_PER_BLOCK;
  localparam int AAW = $clog2(TOTAL_SECS * SEC_BYTES);
  localparam int BAW = $clog2(BUF_SLOTS * SEC_BYTES);
  localparam int SW  = $clog2(TOTAL_SECS);
  localparam int CW  = $clog2(SECS_PER_BLOCK * SEC_BYTES + 1);

  state_t state;
  phase_t phase;
  logic          spareSel, copyPend;
  logic [SW-1:0] baseSec, destSec;
  logic [1:0]    bufSlot;
  logic [CW-1:0] byteCnt, runLen;

  int unsigned srcSec, dstSec, secCnt, eraseBlk, unitBytes, arrFull, bufFull;
  logic srcOk, dstOk, eraseOk;

  function automatic int unsigned blockIndex(input logic [15:0] r);
    int unsigned b;
    b = 32'(r[11:0]);
    if (r[15]) b = b | DENSITY_MASK;
    return b;
  endfunction

  function automatic int unsigned sectorOf(input logic [15:0] blk, input logic [15:0] pg);
    return 32'(pg[1:0]) + ((32'(pg[7:2]) + (blockIndex(blk) << 6)) << 2);
  endfunction

  always_comb begin
    srcSec   = sectorOf(blockAddr, pageAddr);
    dstSec   = sectorOf(destBlockAddr, destPageAddr);
    secCnt   = (bufCtrl[1:0] == 2'd0) ? 32'd4 : 32'(bufCtrl[1:0]);
    srcOk    = (srcSec + secCnt) <= TOTAL_SECS;
    dstOk    = (dstSec + secCnt) <= TOTAL_SECS;
    eraseBlk = blockIndex(blockAddr);
    eraseOk  = eraseBlk < NUM_BLOCKS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= PH_LOAD;
      spareSel <= 1'b0;
      copyPend <= 1'b0;
      baseSec  <= '0;
      destSec  <= '0;
      bufSlot  <= '0;
      byteCnt  <= '0;
      runLen   <= '0;
      errCmd   <= 1'b0;
      errLoad  <= 1'b0;
      errProg  <= 1'b0;
      errErase <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          errCmd   <= 1'b0;
          errLoad  <= 1'b0;
          errProg  <= 1'b0;
          errErase <= 1'b0;
          byteCnt  <= '0;
          copyPend <= 1'b0;
          bufSlot  <= bufCtrl[9:8];
          baseSec  <= SW'(srcSec);
          destSec  <= SW'(dstSec);
          state    <= ST_RUN;
          case (opcode)
            OP_LOAD_MAIN, OP_LOAD_SPARE: begin
              phase    <= PH_LOAD;
              spareSel <= (opcode == OP_LOAD_SPARE);
              runLen   <= CW'(secCnt * ((opcode == OP_LOAD_SPARE) ? SPARE_BYTES : SEC_BYTES));
              if (!srcOk) begin
                errCmd  <= 1'b1;
                errLoad <= 1'b1;
                state   <= ST_DONE;
              end
            end
            OP_PROG_MAIN, OP_PROG_SPARE: begin
              phase    <= PH_PROG;
              spareSel <= (opcode == OP_PROG_SPARE);
              runLen   <= CW'(secCnt * ((opcode == OP_PROG_SPARE) ? SPARE_BYTES : SEC_BYTES));
              if (!srcOk) begin
                errCmd  <= 1'b1;
                errProg <= 1'b1;
                state   <= ST_DONE;
              end
            end
            OP_COPY_BACK: begin
              phase    <= PH_LOAD;
              spareSel <= 1'b0;
              copyPend <= 1'b1;
              runLen   <= CW'(secCnt * SEC_BYTES);
              if (!(srcOk && dstOk)) begin
                errCmd  <= 1'b1;
                errProg <= 1'b1;
                state   <= ST_DONE;
              end
            end
            OP_ERASE_ONE, OP_ERASE_MULTI: begin
              phase    <= PH_ERASE_MAIN;
              spareSel <= 1'b0;
              baseSec  <= SW'(eraseBlk * SECS_PER_BLOCK);
              runLen   <= CW'(SECS_PER_BLOCK * SEC_BYTES);
              if (!eraseOk) begin
                errCmd   <= 1'b1;
                errErase <= 1'b1;
                state    <= ST_DONE;
              end
            end
            default: begin
              errCmd <= 1'b1;
              state  <= ST_DONE;
            end
          endcase
        end
        ST_RUN: begin
          if (byteCnt == runLen - CW'(1)) begin
            byteCnt <= '0;
            if (phase == PH_LOAD && copyPend) begin
              phase    <= PH_PROG;
              copyPend <= 1'b0;
              baseSec  <= destSec;
            end else if (phase == PH_ERASE_MAIN) begin
              phase  <= PH_ERASE_SPARE;
              runLen <= CW'(SECS_PER_BLOCK * SPARE_BYTES);
            end else begin
              state <= ST_DONE;
            end
          end else begin
            byteCnt <= byteCnt + CW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    if (state == ST_RUN) begin
      case (phase)
        PH_LOAD: strobe.load  = 1'b1;
        PH_PROG: strobe.prog  = 1'b1;
        default: strobe.erase = 1'b1;
      endcase
      strobe.spare = (phase == PH_ERASE_SPARE) ||
                     ((phase != PH_ERASE_MAIN) && spareSel);
    end
    unitBytes = strobe.spare ? SPARE_BYTES : SEC_BYTES;
    arrFull   = 32'(baseSec) * unitBytes + 32'(byteCnt);
    bufFull   = 32'(bufSlot) * unitBytes + 32'(byteCnt);
    arrIdx    = arrFull[AAW-1:0];
    bufIdx    = bufFull[BAW-1:0];
  end

  assign busy = (state == ST_RUN);
  assign done = (state == ST_DONE);

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r11_run_ends_in_done: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));
  a_r11_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (byteCnt < runLen));
  a_r9_err_has_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (errLoad || errProg || errErase) |-> errCmd);
  a_r12_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.prog, strobe.erase}));
endmodule

// File: rtl/nand_eng_dp.sv
module nand_eng_dp
  import nand_eng_pkg::*;
#(
  parameter int NUM_BLOCKS  = 2,
  parameter int SEC_BYTES   = 4,
  parameter int SPARE_BYTES = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobe,
  input  logic [$clog2(NUM_BLOCKS*SECS_PER_BLOCK*SEC_BYTES)-1:0] arrIdx,
  input  logic [$clog2(BUF_SLOTS*SEC_BYTES)-1:0] bufIdx,
  input  logic    hostWe,
  input  logic    hostSpare,
  input  logic [$clog2(BUF_SLOTS*SEC_BYTES)-1:0] hostAddr,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata
);
  localparam int TOTAL_SECS  = NUM_BLOCKS * SECS_PER_BLOCK;
  localparam int MAIN_BYTES  = TOTAL_SECS * SEC_BYTES;
  localparam int SPR_BYTES   = TOTAL_SECS * SPARE_BYTES;
  localparam int AAW = $clog2(MAIN_BYTES);
  localparam int SAW = $clog2(SPR_BYTES);
  localparam int BAW = $clog2(BUF_SLOTS * SEC_BYTES);
  localparam int SBW = $clog2(BUF_SLOTS * SPARE_BYTES);

  logic [7:0] mainArr  [MAIN_BYTES];
  logic [7:0] spareArr [SPR_BYTES];
  logic [7:0] mainBuf  [BUF_SLOTS*SEC_BYTES];
  logic [7:0] spareBuf [BUF_SLOTS*SPARE_BYTES];

  logic [7:0] arrByte, bufByte, wrByte;

  always_comb begin
    arrByte = strobe.spare ? spareArr[arrIdx[SAW-1:0]] : mainArr[arrIdx];
    bufByte = strobe.spare ? spareBuf[bufIdx[SBW-1:0]] : mainBuf[bufIdx];
    wrByte  = strobe.erase ? 8'hFF : (arrByte & bufByte);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MAIN_BYTES; i++) mainArr[i] <= 8'hFF;
      for (int i = 0; i < SPR_BYTES; i++)  spareArr[i] <= 8'hFF;
    end else if (strobe.prog || strobe.erase) begin
      if (strobe.spare) spareArr[arrIdx[SAW-1:0]] <= wrByte;
      else              mainArr[arrIdx]           <= wrByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_SLOTS*SEC_BYTES; i++)   mainBuf[i]  <= 8'h00;
      for (int i = 0; i < BUF_SLOTS*SPARE_BYTES; i++) spareBuf[i] <= 8'h00;
    end else if (strobe.load) begin
      if (strobe.spare) spareBuf[bufIdx[SBW-1:0]] <= arrByte;
      else              mainBuf[bufIdx]           <= arrByte;
    end else if (hostWe) begin
      if (hostSpare) spareBuf[hostAddr[SBW-1:0]] <= hostWdata;
      else           mainBuf[hostAddr]           <= hostWdata;
    end
  end

  assign hostRdata = hostSpare ? spareBuf[hostAddr[SBW-1:0]] : mainBuf[hostAddr];

  // Capture of each array write for the checks below.
  logic           chkValid, chkErase, chkSpare;
  logic [AAW-1:0] chkIdx;
  logic [7:0]     chkOld, chkBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkValid <= 1'b0;
      chkErase <= 1'b0;
      chkSpare <= 1'b0;
      chkIdx   <= '0;
      chkOld   <= '0;
      chkBuf   <= '0;
    end else begin
      chkValid <= strobe.prog || strobe.erase;
      chkErase <= strobe.erase;
      chkSpare <= strobe.spare;
      chkIdx   <= arrIdx;
      chkOld   <= arrByte;
      chkBuf   <= bufByte;
    end
  end

  a_r5_prog_and_main: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && !chkErase && !chkSpare) |-> (mainArr[chkIdx] == (chkOld & chkBuf)));
  a_r6_prog_and_spare: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && !chkErase && chkSpare) |-> (spareArr[chkIdx[SAW-1:0]] == (chkOld & chkBuf)));
  a_r7_erase_main_ones: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && chkErase && !chkSpare) |-> (mainArr[chkIdx] == 8'hFF));
  a_r7_erase_spare_ones: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && chkErase && chkSpare) |-> (spareArr[chkIdx[SAW-1:0]] == 8'hFF));
endmodule

// File: rtl/nand_array_engine.sv
module nand_array_engine
  import nand_eng_pkg::*;
#(
  parameter int NUM_BLOCKS   = 2,
  parameter int SEC_BYTES    = 4,
  parameter int SPARE_BYTES  = 1,
  parameter int DENSITY_MASK = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [15:0] blockAddr,
  input  logic [15:0] pageAddr,
  input  logic [15:0] destBlockAddr,
  input  logic [15:0] destPageAddr,
  input  logic [15:0] bufCtrl,
  input  logic        bufWe,
  input  logic        bufSpare,
  input  logic [$clog2(BUF_SLOTS*SEC_BYTES)-1:0] bufAddr,
  input  logic [7:0]  bufWdata,
  output logic [7:0]  bufRdata,
  output logic        busy,
  output logic        done,
  output logic        errCmd,
  output logic        errLoad,
  output logic        errProg,
  output logic        errErase
);
  localparam int AAW = $clog2(NUM_BLOCKS * SECS_PER_BLOCK * SEC_BYTES);
  localparam int BAW = $clog2(BUF_SLOTS * SEC_BYTES);

  strobe_t        strobe;
  logic [AAW-1:0] arrIdx;
  logic [BAW-1:0] bufIdx;

  nand_eng_ctrl #(
    .NUM_BLOCKS(NUM_BLOCKS), .SEC_BYTES(SEC_BYTES),
    .SPARE_BYTES(SPARE_BYTES), .DENSITY_MASK(DENSITY_MASK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .blockAddr(blockAddr), .pageAddr(pageAddr),
    .destBlockAddr(destBlockAddr), .destPageAddr(destPageAddr),
    .bufCtrl(bufCtrl), .strobe(strobe), .arrIdx(arrIdx), .bufIdx(bufIdx),
    .busy(busy), .done(done), .errCmd(errCmd), .errLoad(errLoad),
    .errProg(errProg), .errErase(errErase)
  );

  nand_eng_dp #(
    .NUM_BLOCKS(NUM_BLOCKS), .SEC_BYTES(SEC_BYTES), .SPARE_BYTES(SPARE_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .arrIdx(arrIdx), .bufIdx(bufIdx),
    .hostWe(bufWe), .hostSpare(bufSpare), .hostAddr(bufAddr),
    .hostWdata(bufWdata), .hostRdata(bufRdata)
  );
endmodule

// File: tb/nand_array_engine_tb.sv
`timescale 1ns/1ps
module nand_array_engine_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] blockAddr = '0, pageAddr = '0, destBlockAddr = '0, destPageAddr = '0, bufCtrl = '0;
  logic        bufWe = 1'b0, bufSpare = 1'b0;
  logic [3:0]  bufAddr = '0;
  logic [7:0]  bufWdata = '0;
  logic [7:0]  bufRdata;
  logic        busy, done, errCmd, errLoad, errProg, errErase;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int lat;

  always #2 clk = ~clk;

  nand_array_engine u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .blockAddr(blockAddr), .pageAddr(pageAddr),
    .destBlockAddr(destBlockAddr), .destPageAddr(destPageAddr),
    .bufCtrl(bufCtrl), .bufWe(bufWe), .bufSpare(bufSpare), .bufAddr(bufAddr),
    .bufWdata(bufWdata), .bufRdata(bufRdata), .busy(busy), .done(done),
    .errCmd(errCmd), .errLoad(errLoad), .errProg(errProg), .errErase(errErase)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic [15:0] blk;
    logic [15:0] pg;
    logic [15:0] bc;
    logic [3:0]  err;
    logic [15:0] lat;
  } vec_t;

  localparam int NV = 13;
  // err = {cmd, load, prog, erase}
  localparam vec_t VECS [NV] = '{
    '{8'h00, 16'h0000, 16'h0000, 16'h0001, 4'b0000, 16'd5},   // R4 count 1
    '{8'h00, 16'h0000, 16'h0000, 16'h0002, 4'b0000, 16'd9},   // R4 count 2
    '{8'h00, 16'h0000, 16'h0000, 16'h0003, 4'b0000, 16'd13},  // R4 count 3
    '{8'h00, 16'h0000, 16'h0000, 16'h0000, 4'b0000, 16'd17},  // R4 zero means 4
    '{8'h13, 16'h0000, 16'h0000, 16'h0000, 4'b0000, 16'd5},   // R6 spare count 4
    '{8'h00, 16'h0002, 16'h0000, 16'h0001, 4'b1100, 16'd1},   // R9 no such block
    '{8'h00, 16'h0001, 16'h00FF, 16'h0002, 4'b1100, 16'd1},   // R9 runs past end
    '{8'h00, 16'h0001, 16'h00FF, 16'h0001, 4'b0000, 16'd5},   // R9 last sector ok
    '{8'h80, 16'h8002, 16'h0000, 16'h0001, 4'b1010, 16'd1},   // R3 folded block 3
    '{8'h1A, 16'h0001, 16'h00FE, 16'h0000, 4'b1010, 16'd1},   // R9 spare past end
    '{8'h94, 16'h0002, 16'h0000, 16'h0000, 4'b1001, 16'd1},   // R9 erase bad block
    '{8'h55, 16'h0000, 16'h0000, 16'h0001, 4'b1000, 16'd1},   // R10 unknown
    '{8'h71, 16'h0000, 16'h0000, 16'h0001, 4'b1000, 16'd1}    // R10 unknown
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [7:0] op, input logic [15:0] blk, input logic [15:0] pg,
                       input logic [15:0] dblk, input logic [15:0] dpg, input logic [15:0] bc);
    @(negedge clk);
    opcode = op; blockAddr = blk; pageAddr = pg;
    destBlockAddr = dblk; destPageAddr = dpg; bufCtrl = bc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic wbuf(input logic sp, input int a, input logic [7:0] d);
    @(negedge clk);
    bufWe = 1'b1; bufSpare = sp; bufAddr = a[3:0]; bufWdata = d;
    @(negedge clk);
    bufWe = 1'b0;
  endtask

  task automatic cbuf(input string req, input logic sp, input int a, input logic [7:0] exp);
    @(negedge clk);
    bufSpare = sp; bufAddr = a[3:0];
    #1;
    chk(req, int'(bufRdata), int'(exp));
  endtask

  function automatic int errs();
    return int'({errCmd, errLoad, errProg, errErase});
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 errs", errs(), 0);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      runOp(VECS[i].op, VECS[i].blk, VECS[i].pg, 16'h0, 16'h0, VECS[i].bc);
      chk($sformatf("R11 latency vec%0d", i), lat, int'(VECS[i].lat));
      chk($sformatf("R9 R10 errors vec%0d", i), errs(), int'(VECS[i].err));
    end

    // R1: array erased at reset (full buffer loaded by vector 3, spare by 4)
    for (int i = 0; i < 16; i++) cbuf("R1 main ones", 1'b0, i, 8'hFF);
    for (int i = 0; i < 4; i++)  cbuf("R1 spare ones", 1'b1, i, 8'hFF);

    // R2 R4: program sector 5 from slot 2
    wbuf(1'b0, 8, 8'hA5); wbuf(1'b0, 9, 8'h5A); wbuf(1'b0, 10, 8'hC3); wbuf(1'b0, 11, 8'h0F);
    runOp(8'h80, 16'h0000, 16'h0005, 16'h0, 16'h0, 16'h0201);
    chk("R11 prog latency", lat, 5);
    chk("R11 errors cleared by good start", errs(), 0);
    for (int i = 0; i < 4; i++) wbuf(1'b0, i, 8'h00);
    runOp(8'h00, 16'h0000, 16'h0005, 16'h0, 16'h0, 16'h0001);
    cbuf("R2 sector5 b0", 1'b0, 0, 8'hA5);
    cbuf("R2 sector5 b1", 1'b0, 1, 8'h5A);
    cbuf("R2 sector5 b2", 1'b0, 2, 8'hC3);
    cbuf("R2 sector5 b3", 1'b0, 3, 8'h0F);
    runOp(8'h00, 16'h0000, 16'h0004, 16'h0, 16'h0, 16'h0101);
    cbuf("R2 sector4 untouched", 1'b0, 4, 8'hFF);
    cbuf("R2 sector4 untouched", 1'b0, 7, 8'hFF);

    // R5: second program ANDs
    wbuf(1'b0, 8, 8'hF0); wbuf(1'b0, 9, 8'hF0); wbuf(1'b0, 10, 8'h3C); wbuf(1'b0, 11, 8'hFF);
    runOp(8'h80, 16'h0000, 16'h0005, 16'h0, 16'h0, 16'h0201);
    runOp(8'h00, 16'h0000, 16'h0005, 16'h0, 16'h0, 16'h0001);
    cbuf("R5 and b0", 1'b0, 0, 8'hA0);
    cbuf("R5 and b1", 1'b0, 1, 8'h50);
    cbuf("R5 and b2", 1'b0, 2, 8'h00);
    cbuf("R5 and b3", 1'b0, 3, 8'h0F);

    // R3: density bit selects block 1
    wbuf(1'b0, 0, 8'h11); wbuf(1'b0, 1, 8'h22); wbuf(1'b0, 2, 8'h33); wbuf(1'b0, 3, 8'h44);
    runOp(8'h80, 16'h8000, 16'h0000, 16'h0, 16'h0, 16'h0001);
    chk("R3 prog errors", errs(), 0);
    for (int i = 12; i < 16; i++) wbuf(1'b0, i, 8'h00);
    runOp(8'h00, 16'h0001, 16'h0000, 16'h0, 16'h0, 16'h0301);
    cbuf("R3 folded b0", 1'b0, 12, 8'h11);
    cbuf("R3 folded b3", 1'b0, 15, 8'h44);

    // R4: buffer slot wrap (slot 3 then slot 0)
    wbuf(1'b0, 0, 8'h66); wbuf(1'b0, 1, 8'h77); wbuf(1'b0, 2, 8'h88); wbuf(1'b0, 3, 8'h99);
    runOp(8'h80, 16'h0001, 16'h0008, 16'h0, 16'h0, 16'h0302);
    chk("R4 wrap latency", lat, 9);
    runOp(8'h00, 16'h0001, 16'h0009, 16'h0, 16'h0, 16'h0101);
    cbuf("R4 wrap b0", 1'b0, 4, 8'h66);
    cbuf("R4 wrap b3", 1'b0, 7, 8'h99);
    runOp(8'h00, 16'h0001, 16'h0008, 16'h0, 16'h0, 16'h0101);
    cbuf("R4 slot3 source", 1'b0, 4, 8'h11);

    // R6: spare program/load, main untouched
    wbuf(1'b1, 1, 8'h3C);
    runOp(8'h1A, 16'h0000, 16'h0002, 16'h0, 16'h0, 16'h0101);
    chk("R6 spare prog latency", lat, 2);
    runOp(8'h13, 16'h0000, 16'h0002, 16'h0, 16'h0, 16'h0301);
    cbuf("R6 spare readback", 1'b1, 3, 8'h3C);
    runOp(8'h13, 16'h0000, 16'h0003, 16'h0, 16'h0, 16'h0001);
    cbuf("R6 next spare ones", 1'b1, 0, 8'hFF);
    runOp(8'h00, 16'h0000, 16'h0002, 16'h0, 16'h0, 16'h0201);
    cbuf("R6 main untouched", 1'b0, 8, 8'hFF);

    // R8: copy-back sector 5 to block 1 sector 16
    runOp(8'h1B, 16'h0000, 16'h0005, 16'h0001, 16'h0010, 16'h0001);
    chk("R8 copy latency", lat, 9);
    chk("R8 copy errors", errs(), 0);
    for (int i = 8; i < 12; i++) wbuf(1'b0, i, 8'h00);
    runOp(8'h00, 16'h0001, 16'h0010, 16'h0, 16'h0, 16'h0201);
    cbuf("R8 copy b0", 1'b0, 8, 8'hA0);
    cbuf("R8 copy b1", 1'b0, 9, 8'h50);
    cbuf("R8 copy b3", 1'b0, 11, 8'h0F);
    runOp(8'h1B, 16'h0000, 16'h0005, 16'h0002, 16'h0000, 16'h0001);
    chk("R9 copy bad dest", errs(), 4'b1010);

    // R9: failed program leaves array unchanged
    wbuf(1'b0, 0, 8'h00);
    runOp(8'h80, 16'h0001, 16'h00FF, 16'h0, 16'h0, 16'h0002);
    chk("R9 prog past end", errs(), 4'b1010);
    runOp(8'h00, 16'h0001, 16'h00FF, 16'h0, 16'h0, 16'h0101);
    cbuf("R9 last sector unchanged", 1'b0, 4, 8'hFF);

    // R7: erase block 0, block 1 kept
    runOp(8'h94, 16'h0000, 16'h0000, 16'h0, 16'h0, 16'h0000);
    chk("R7 erase latency", lat, 1281);
    chk("R7 erase errors", errs(), 0);
    runOp(8'h00, 16'h0000, 16'h0005, 16'h0, 16'h0, 16'h0001);
    cbuf("R7 main erased", 1'b0, 0, 8'hFF);
    cbuf("R7 main erased", 1'b0, 3, 8'hFF);
    runOp(8'h13, 16'h0000, 16'h0002, 16'h0, 16'h0, 16'h0001);
    cbuf("R7 spare erased", 1'b1, 0, 8'hFF);
    runOp(8'h00, 16'h0001, 16'h0000, 16'h0, 16'h0, 16'h0001);
    cbuf("R7 other block kept", 1'b0, 0, 8'h11);
    runOp(8'h95, 16'h8000, 16'h0000, 16'h0, 16'h0, 16'h0000);
    chk("R7 multi erase latency", lat, 1281);
    runOp(8'h00, 16'h0001, 16'h0000, 16'h0, 16'h0, 16'h0001);
    cbuf("R7 multi erase ones", 1'b0, 0, 8'hFF);

    // R12: start while busy is ignored
    @(negedge clk);
    opcode = 8'h94; blockAddr = 16'h0000; bufCtrl = 16'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    repeat (9) begin @(negedge clk); lat++; end
    opcode = 8'h00; blockAddr = 16'h0002; start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 5000) begin @(negedge clk); lat++; end
    chk("R12 latency unchanged", lat, 1281);
    chk("R12 no error from ignored start", errs(), 0);
    lat = 0;
    repeat (5) begin @(negedge clk); if (done) lat++; end
    chk("R12 single done", lat, 0);
    chk("R12 idle after", int'(busy), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule